// File: doc/BRIEF.md
# Cascadable TDM Audio Frame Port

This block is the serial side of a multichannel audio codec. It talks to a DSP over one time-division-multiplexed link and can be chained with other devices of the same kind. Each device owns a frame register of eight 32-bit slots. At every frame boundary the register takes in a fresh set of converter input (ADC) words. For the rest of the frame it shifts them out one bit per bit clock, and at the same time shifts in whatever arrives on its serial input. At the next boundary the 256 bits that came in are handed to the converter outputs (DACs) as eight words, and a one-cycle strobe marks them.

The devices are chained like this. The DSP's receive pin reads the serial output of the device nearest to it. That device's serial input reads the next device's serial output, and the DSP transmit pin feeds the far end of the chain. With two devices the frame on the link is 512 bit clocks long. The DSP first receives the near device's ADC words and then the far device's ADC words, which pass through the near device on their way. The DAC words the DSP sends walk in the opposite direction. The first 256 bits sent end up in the near device and the last 256 stay in the far device.

A strap input sets the role. A master divides the common master clock down to the bit clock and makes the frame sync. A slave takes both from its pins. All logic runs on the master clock, and bit-clock edges are found by sampling the bit clock in that domain.

Top module: `tdm_chain_port`

## Requirements
- R1: In master mode `bclk_o` is the master clock divided by `CLK_DIV`, with equal high and low phases of `CLK_DIV/2` master clocks.
- R2: In master mode `fsync_o` is high for exactly one bit-clock period, once every `CHAIN_DEVS*NUM_SLOTS*SLOT_W` bit clocks (512 by default). It rises and falls only together with a falling `bclk_o`, and it covers the last bit of each frame.
- R3: In slave mode `bclk_o` and `fsync_o` stay low, and all bit timing comes from `bclk_i` and `fsync_i`.
- R4: `sdata_o` changes only in the master-clock cycle right after a falling bit-clock edge is detected, and `sdata_i` is sampled at rising bit-clock edges.
- R5: A frame boundary is the first falling bit-clock edge after a rising edge that saw frame sync high. At a boundary the register loads `adc_words_i`. Bits then leave MSB first, in slot order L1, L2, L3, L4, R1, R2, R3, R4. Slot k (0 = L1) sits in bits `[(NUM_SLOTS-k)*SLOT_W-1 -: SLOT_W]` of the word bus.
- R6: A bit sampled on `sdata_i` comes out again on `sdata_o` 256 bit clocks later, so a device acts as one stage of the chain.
- R7: At a boundary `dac_words_o` takes the last 256 bits received, in the same slot layout as R5. `dac_valid_o` pulses high for exactly one master clock, one cycle after the boundary's falling edge is detected.
- R8: The first boundary after reset raises no `dac_valid_o`, because no full frame has been received yet.
- R9: During reset `bclk_o`, `fsync_o`, `sdata_o`, `dac_valid_o` and `dac_words_o` are all zero.
- R10: With a master near the DSP and a slave at the far end, the DSP receives the master's ADC words followed by the slave's. The master's DAC words are the first 256 bits the DSP sent, and the slave's are the last 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock shared by all chained devices |
| rst_n | input | 1 | Synchronous active-low reset |
| role_master | input | 1 | Strap: 1 = generate bit clock and frame sync, 0 = take them from pins |
| bclk_i | input | 1 | Bit clock from the link (slave mode) |
| fsync_i | input | 1 | Frame sync from the link (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, else 0) |
| fsync_o | output | 1 | Generated frame sync (master mode, else 0) |
| sdata_i | input | 1 | Serial data from the upstream device or the DSP |
| sdata_o | output | 1 | Serial data toward the DSP or the downstream device |
| adc_words_i | input | NUM_SLOTS*SLOT_W | ADC slot words loaded at each frame boundary |
| dac_words_o | output | NUM_SLOTS*SLOT_W | DAC slot words captured at each frame boundary |
| dac_valid_o | output | 1 | One-cycle strobe when `dac_words_o` is updated |

## Verification
Two instances are chained: a master near a behavioural DSP and a slave at the far end. Six frames run through them. The ADC and DAC payloads cycle through four patterns. A structured pattern tags every word with its frame, device and slot number, so a slot swap, a device swap or a one-bit slip shows up as a wrong tag. All-ones and all-zeros frames show whether a stuck serial bit or a missing load is hidden by the data. Alternating 5555/AAAA words between neighbouring slots expose a bit-order reversal or an off-by-one shift that the structured words might survive. The near device's half and the far device's half are checked separately, which separates the device's own load path (R5) from its pass-through path (R6). The bit-clock period, frame-sync width and spacing, output change timing and the missing first strobe are measured at the pins.

// File: rtl/tdm_chain_pkg.sv
// Package: shared types and helpers for the cascadable TDM frame port.
// Assumes: nothing beyond IEEE 1800-2017.
package tdm_chain_pkg;

    // Role selected by the strap pin
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // Bit clocks in one link frame for a chain of devs devices
    function automatic int link_frame_bits(input int slots, input int slot_w, input int devs);
        return slots * slot_w * devs;
    endfunction

endpackage

// File: rtl/tdm_bclk_gen.sv
// Module: bit clock and frame sync generator used in master mode.
// Divides the master clock by CLK_DIV (even, >= 2) to make the bit clock.
// Frame sync is high for the last bit of each FRAME_BITS-long frame and
// changes together with the falling bit clock. Reset starts one bit before
// the frame end so the first frame begins right away.
module tdm_bclk_gen #(
    parameter int CLK_DIV    = 4,
    parameter int FRAME_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk,
    output logic fsync
);
    localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BW   = $clog2(FRAME_BITS);
    localparam int HALF = CLK_DIV / 2;

    logic [DW-1:0] div_cnt;
    logic [BW-1:0] bit_cnt;
    logic [BW-1:0] bit_nxt;

    // Next bit index, wrapping at the frame length
    always_comb begin
        bit_nxt = (bit_cnt == BW'(FRAME_BITS - 1)) ? '0 : bit_cnt + 1'b1;
    end

    // Divider, bit counter and registered bit clock / frame sync
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= BW'(FRAME_BITS - 2);
            bclk    <= 1'b0;
            fsync   <= 1'b0;
        end else if (en) begin
            if (div_cnt == DW'(CLK_DIV - 1)) begin
                div_cnt <= '0;
                bclk    <= 1'b0;
                bit_cnt <= bit_nxt;
                fsync   <= (bit_nxt == BW'(FRAME_BITS - 1));
            end else begin
                div_cnt <= div_cnt + 1'b1;
                if (div_cnt == DW'(HALF - 1)) begin
                    bclk <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_bclk_edge.sv
// Module: finds bit-clock edges in the master-clock domain.
// Assumes the bit clock is synchronous to clk (both come from one master
// clock), so no synchronizer stages are needed. rise and fall are one-cycle
// pulses and are never high together.
module tdm_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise,
    output logic fall
);
    logic bclk_q;

    // Previous bit-clock level
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    // Edge pulses from the level change
    always_comb begin
        rise = bclk & ~bclk_q;
        fall = ~bclk & bclk_q;
    end

endmodule

// File: rtl/tdm_frame_shifter.sv
// Module: frame shift register acting as one stage of the chain.
// Shifts in sdata_i at rising bit-clock edges and drives sdata_o after
// falling edges. At a frame boundary (a fall after a rise that saw frame
// sync high) it hands the received bits to the DAC word registers and
// reloads itself with the ADC words. Slot 0 occupies the top SLOT_W bits.
module tdm_frame_shifter #(
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rise,
    input  logic                          fall,
    input  logic                          fsync,
    input  logic                          sdata_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0]   adc_words,
    output logic                          sdata_o,
    output logic [NUM_SLOTS*SLOT_W-1:0]   dac_words,
    output logic                          dac_valid
);
    localparam int REG_W = NUM_SLOTS * SLOT_W;

    logic [REG_W-1:0] sr;
    logic             fs_q;
    logic             out_q;
    logic             armed;
    logic             boundary;
    logic             capture;

    assign boundary = fall & fs_q;
    assign capture  = boundary & armed;
    assign sdata_o  = out_q;

    // Frame sync as seen at the latest rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)    fs_q <= 1'b0;
        else if (rise) fs_q <= fsync;
    end

    // Shift on rising edges, parallel load at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (rise)     sr <= {sr[REG_W-2:0], sdata_i};
        else if (boundary) sr <= adc_words;
    end

    // Serial output updated after each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)    out_q <= 1'b0;
        else if (fall) out_q <= boundary ? adc_words[REG_W-1] : sr[REG_W-1];
    end

    // Armed once a first boundary has started a complete frame
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (boundary) armed <= 1'b1;
    end

    // One-cycle strobe for each captured frame
    always_ff @(posedge clk) begin
        if (!rst_n) dac_valid <= 1'b0;
        else        dac_valid <= capture;
    end

    // Per-slot DAC word registers
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [SLOT_W-1:0] word_q;

        // Hold the slot word received in the last frame
        always_ff @(posedge clk) begin
            if (!rst_n)       word_q <= '0;
            else if (capture) word_q <= sr[REG_W-1-k*SLOT_W -: SLOT_W];
        end

        assign dac_words[REG_W-1-k*SLOT_W -: SLOT_W] = word_q;
    end

endmodule

// File: rtl/tdm_chain_port.sv
// Module: top of the cascadable TDM frame port.
// A master makes bit clock and frame sync from clk. A slave uses the pins.
// Both roles run their frame logic from the same view of the bit clock, so
// chained devices on one master clock shift on the same clk cycle.
// Assumes every device in the chain is clocked by the same clk.
module tdm_chain_port #(
    parameter int SLOT_W     = 32,
    parameter int NUM_SLOTS  = 8,
    parameter int CHAIN_DEVS = 2,
    parameter int CLK_DIV    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        role_master,
    input  logic                        bclk_i,
    input  logic                        fsync_i,
    output logic                        bclk_o,
    output logic                        fsync_o,
    input  logic                        sdata_i,
    output logic                        sdata_o,
    input  logic [NUM_SLOTS*SLOT_W-1:0] adc_words_i,
    output logic [NUM_SLOTS*SLOT_W-1:0] dac_words_o,
    output logic                        dac_valid_o
);
    import tdm_chain_pkg::*;

    localparam int FRAME_BITS = link_frame_bits(NUM_SLOTS, SLOT_W, CHAIN_DEVS);

    role_e role;
    logic  gen_bclk;
    logic  gen_fsync;
    logic  bclk_sel;
    logic  fsync_sel;
    logic  bclk_rise;
    logic  bclk_fall;

    assign role = role_e'(role_master);

    tdm_bclk_gen #(
        .CLK_DIV    (CLK_DIV),
        .FRAME_BITS (FRAME_BITS)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (role == ROLE_MASTER),
        .bclk  (gen_bclk),
        .fsync (gen_fsync)
    );

    // Pick the timing source and drive the link outputs by role
    always_comb begin
        if (role == ROLE_MASTER) begin
            bclk_sel  = gen_bclk;
            fsync_sel = gen_fsync;
            bclk_o    = gen_bclk;
            fsync_o   = gen_fsync;
        end else begin
            bclk_sel  = bclk_i;
            fsync_sel = fsync_i;
            bclk_o    = 1'b0;
            fsync_o   = 1'b0;
        end
    end

    tdm_bclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (bclk_sel),
        .rise  (bclk_rise),
        .fall  (bclk_fall)
    );

    tdm_frame_shifter #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (bclk_rise),
        .fall      (bclk_fall),
        .fsync     (fsync_sel),
        .sdata_i   (sdata_i),
        .adc_words (adc_words_i),
        .sdata_o   (sdata_o),
        .dac_words (dac_words_o),
        .dac_valid (dac_valid_o)
    );

endmodule

// File: rtl/tdm_chain_port_sva.sv
// Checker: timing properties of the frame port, bound to every instance.
// Watches only the ports and the detected bit-clock falling edge.
module tdm_chain_port_sva #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic role_master,
    input logic bclk_o,
    input logic fsync_o,
    input logic sdata_o,
    input logic dac_valid_o,
    input logic bclk_fall
);
    localparam int HALF = CLK_DIV / 2;

    logic       prev_b;
    logic       seen;
    logic [7:0] run_cnt;

    // Length of the current bit-clock phase in master clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_b  <= 1'b0;
            seen    <= 1'b0;
            run_cnt <= '0;
        end else begin
            prev_b <= bclk_o;
            if (bclk_o != prev_b) begin
                run_cnt <= 8'd1;
                seen    <= 1'b1;
            end else if (run_cnt != 8'hFF) begin
                run_cnt <= run_cnt + 8'd1;
            end
        end
    end

    // R1: each bit-clock phase lasts CLK_DIV/2 master clocks
    a_r1_bclk_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && seen && bclk_o != prev_b) |-> run_cnt == 8'(HALF));

    // R2: frame sync rises only with a falling bit clock
    a_r2_fsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && $rose(fsync_o)) |-> $fell(bclk_o));

    // R2: frame sync falls only with a falling bit clock
    a_r2_fsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && $fell(fsync_o)) |-> $fell(bclk_o));

    // R3: a slave keeps its clock outputs low
    a_r3_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !role_master |-> (!bclk_o && !fsync_o));

    // R4: serial output moves only after a detected falling edge
    a_r4_sdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> $stable(sdata_o));

    // R7: DAC strobe is a single cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid_o |=> !dac_valid_o);

    // R7: DAC strobe follows a falling bit-clock edge
    a_r7_valid_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid_o |-> $past(bclk_fall));

endmodule

bind tdm_chain_port tdm_chain_port_sva #(
    .CLK_DIV (CLK_DIV)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_master (role_master),
    .bclk_o      (bclk_o),
    .fsync_o     (fsync_o),
    .sdata_o     (sdata_o),
    .dac_valid_o (dac_valid_o),
    .bclk_fall   (bclk_fall)
);

// File: tb/tdm_chain_port_bench.sv
// Bench: master near a behavioural DSP, slave at the far end of the chain.
// Scoreboard: start_frame pushes expected receive bits and DAC frames into
// queues; the monitor pops and compares as bits and strobes appear.
module tdm_chain_port_bench;
    localparam int SW   = 32;
    localparam int NS   = 8;
    localparam int DEVS = 2;
    localparam int DIV  = 4;
    localparam int DW   = SW * NS;
    localparam int FB   = DW * DEVS;
    localparam int LAST_FRAME = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          bclk1, fs1, sd1_o, val1;
    logic          bclk2, fs2, sd2_o, val2;
    logic          dsp_tx;
    logic [DW-1:0] adc1, adc2, dac1, dac2;

    int checks = 0;
    int fails  = 0;

    tdm_chain_port u_tdm_chain_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_master (1'b1),
        .bclk_i      (1'b0),
        .fsync_i     (1'b0),
        .bclk_o      (bclk1),
        .fsync_o     (fs1),
        .sdata_i     (sd2_o),
        .sdata_o     (sd1_o),
        .adc_words_i (adc1),
        .dac_words_o (dac1),
        .dac_valid_o (val1)
    );

    tdm_chain_port u_tdm_chain_port_far (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_master (1'b0),
        .bclk_i      (bclk1),
        .fsync_i     (fs1),
        .bclk_o      (bclk2),
        .fsync_o     (fs2),
        .sdata_i     (dsp_tx),
        .sdata_o     (sd2_o),
        .adc_words_i (adc2),
        .dac_words_o (dac2),
        .dac_valid_o (val2)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Frame payloads: structured tags, all ones, all zeros, alternating
    function automatic logic [DW-1:0] make_frame(input int n, input int dev);
        logic [DW-1:0] f;
        for (int k = 0; k < NS; k++) begin
            logic [SW-1:0] w;
            case (n % 4)
                1:       w = '1;
                2:       w = '0;
                3:       w = (k % 2 == 1) ? 32'h5555_AAAA : 32'hAAAA_5555;
                default: w = {4'hC, 4'(dev), 8'(n), 8'(k), 8'h3C};
            endcase
            f[DW-1-k*SW -: SW] = w;
        end
        return f;
    endfunction

    logic          exp_rx[$];
    logic [DW-1:0] exp_dac1[$];
    logic [DW-1:0] exp_dac2[$];
    logic [FB-1:0] cur_tx;

    // Driver: expected bits and DAC frames for the frame now starting
    task automatic start_frame(input int b);
        for (int i = DW - 1; i >= 0; i--) exp_rx.push_back(adc1[i]);
        for (int i = DW - 1; i >= 0; i--) exp_rx.push_back(adc2[i]);
        cur_tx = {make_frame(b + 1, 5), make_frame(b + 2, 6)};
        exp_dac1.push_back(cur_tx[FB-1 -: DW]);
        exp_dac2.push_back(cur_tx[DW-1:0]);
    endtask

    task automatic compare_dac(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        for (int k = 0; k < NS; k++) begin
            check(act[DW-1-k*SW -: SW] == exp[DW-1-k*SW -: SW], req,
                  act[DW-1-k*SW -: SW], exp[DW-1-k*SW -: SW]);
        end
    endtask

    logic prev_b, prev_sd, start_pend, rx_on, adc_change, prev_rise_fs, seen_b, seen_fs;
    int   cyc_b, fall_age, rx_idx, tx_idx, boundaries, rises_since, nval1, nval2, tail;
    logic done;

    // Monitor and behavioural DSP, sampled away from the active clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_b = 0; prev_sd = 0; start_pend = 0; rx_on = 0; adc_change = 0;
            prev_rise_fs = 0; seen_b = 0; seen_fs = 0;
            cyc_b = 0; fall_age = 0; rx_idx = 0; tx_idx = 0; boundaries = 0;
            rises_since = 0; nval1 = 0; nval2 = 0; tail = 0; done = 0;
        end else begin
            cyc_b++;
            fall_age++;
            // R7 / R10: DAC words against what the DSP sent
            if (val1) begin
                nval1++;
                check(boundaries >= 2, "R8 no strobe at first boundary (dev1)", 32'(boundaries), 32'd2);
                if (exp_dac1.size() > 0) compare_dac(dac1, exp_dac1.pop_front(), "R7/R10 near device DAC word");
            end
            if (val2) begin
                nval2++;
                check(boundaries >= 2, "R8 no strobe at first boundary (dev2)", 32'(boundaries), 32'd2);
                if (exp_dac2.size() > 0) compare_dac(dac2, exp_dac2.pop_front(), "R7/R10 far device DAC word");
            end
            // R1: phase length of the generated bit clock
            if (bclk1 != prev_b) begin
                if (seen_b) check(cyc_b == DIV / 2, "R1 bit clock phase", 32'(cyc_b), 32'(DIV / 2));
                seen_b = 1;
                cyc_b  = 0;
            end
            // Rising bit clock: DSP samples, frame sync bookkeeping
            if (bclk1 && !prev_b) begin
                rises_since++;
                check(!bclk2 && !fs2, "R3 slave clock outputs low", {30'd0, bclk2, fs2}, 32'd0);
                if (rx_on && exp_rx.size() > 0) begin
                    logic e;
                    e = exp_rx.pop_front();
                    check(sd1_o == e, (rx_idx < DW) ? "R5 near device ADC bit" : "R6 far device bit via chain",
                          {31'd0, sd1_o}, {31'd0, e});
                    rx_idx++;
                end
                if (adc_change) begin
                    adc1 = make_frame(boundaries, 1);
                    adc2 = make_frame(boundaries, 2);
                    adc_change = 0;
                end
                if (fs1) begin
                    if (seen_fs) check(rises_since == FB, "R2 frame sync spacing", 32'(rises_since), 32'(FB));
                    check(!prev_rise_fs, "R2 frame sync one bit wide", {31'd0, prev_rise_fs}, 32'd0);
                    seen_fs = 1;
                    rises_since = 0;
                    start_pend = 1;
                end
                prev_rise_fs = fs1;
            end
            // Falling bit clock: frame start and DSP transmit
            if (!bclk1 && prev_b) begin
                fall_age = 0;
                if (start_pend) begin
                    start_pend = 0;
                    boundaries++;
                    if (boundaries == 2) begin
                        check(nval1 == 0 && nval2 == 0, "R8 first boundary raised no strobe",
                              32'(nval1 + nval2), 32'd0);
                    end
                    start_frame(boundaries);
                    rx_on = 1; rx_idx = 0; tx_idx = 0; adc_change = 1;
                end
                dsp_tx = (tx_idx < FB) ? cur_tx[FB-1-tx_idx] : 1'b0;
                tx_idx++;
            end
            // R4: serial output changes only just after a falling edge
            if (sd1_o != prev_sd) begin
                check(fall_age <= 2, "R4 sdata_o change timing", 32'(fall_age), 32'd2);
            end
            prev_sd = sd1_o;
            prev_b  = bclk1;
            if (boundaries == LAST_FRAME) begin
                tail++;
                if (tail == 20) done = 1;
            end
        end
    end

    // Reset, run, watchdog and summary
    initial begin
        int cyc;
        rst_n  = 1'b0;
        dsp_tx = 1'b0;
        cur_tx = '0;
        adc1   = make_frame(0, 1);
        adc2   = make_frame(0, 2);
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R9: reset state at the pins of both devices
        check(!bclk1 && !fs1 && !sd1_o && !val1, "R9 near device reset outputs",
              {28'd0, bclk1, fs1, sd1_o, val1}, 32'd0);
        check(!bclk2 && !fs2 && !sd2_o && !val2, "R9 far device reset outputs",
              {28'd0, bclk2, fs2, sd2_o, val2}, 32'd0);
        check(dac1 == '0 && dac2 == '0, "R9 DAC words cleared", dac1[31:0] | dac2[31:0], 32'd0);
        rst_n = 1'b1;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        check(done, "watchdog expired", 32'(cyc), 32'd0);
        // R7: one strobe per completed frame on each device
        check(nval1 == LAST_FRAME - 1, "R7 near device strobe count", 32'(nval1), 32'(LAST_FRAME - 1));
        check(nval2 == LAST_FRAME - 1, "R7 far device strobe count", 32'(nval2), 32'(LAST_FRAME - 1));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule